// File: doc/BRIEF.md
# Sparse Hit-Channel Serial Readout

This block sends out, over one serial line, the stored results of only those channels that saw a hit. A single start pulse captures a hit mask. The block then visits the channels from 0 upward. For each channel whose mask bit is set, it reads that channel's timestamp, charge and time words through a register-read port. It then shifts out a fixed 52-bit frame, most significant bit first, with a valid strobe held high over the frame. A channel whose bit is clear costs one idle cycle and produces no output.

Every field of a frame is converted from binary to Gray code before it is sent. The fields, from the first bit sent to the last, are the 4-bit channel number, the 24-bit timestamp, the 12-bit charge and the 12-bit time. The block is meant to run on a 10 MHz readout clock. At that rate a readout of all 16 channels finishes well inside 100 µs. A pending mask is visible at the ports, and each bit clears once its channel's frame has left.

Top module: `hit_serial_readout`

## Requirements
- R1: After reset, busy, done and ser_valid are low and pend_mask is all zero.
- R2: When start is sampled high while busy is low and hit_mask is nonzero, pend_mask takes hit_mask on that edge. busy stays high from then until the cycle in which done is high.
- R3: Frames come out only for channels whose pend_mask bit is set, in ascending channel order.
- R4: Each frame is 52 bits sent MSB first. Bits 51..48 carry the channel number, bits 47..24 the timestamp read for that channel, bits 23..12 its charge and bits 11..0 its time.
- R5: Every field is Gray coded as g = b XOR (b >> 1) over the field's own width.
- R6: ser_valid is high for exactly 52 consecutive cycles per frame, and low between frames.
- R7: Each channel costs one scan cycle, and each hit channel costs another 52 cycles. done is high 16 + 52·h cycles after the start edge, where h is the number of hit channels. With all 16 channels hit this is 848 cycles, which is within 1000 cycles (100 µs at 10 MHz).
- R8: A start with an all-zero hit_mask gives done in the cycle right after the start edge, and busy stays low.
- R9: A channel's pend_mask bit clears on the edge that ends its frame. After the run pend_mask is zero.
- R10: start is ignored while busy is high. It changes neither pend_mask nor the frames sent.
- R11: done is a single-cycle pulse, and busy is low while done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a readout of hit_mask |
| hit_mask | input | 16 | One bit per channel that registered a hit |
| rd_en | output | 1 | Read strobe into the result banks |
| rd_ch | output | 4 | Channel being read |
| rd_ts | input | 24 | Binary timestamp of channel rd_ch |
| rd_charge | input | 12 | Binary charge of channel rd_ch |
| rd_time | input | 12 | Binary fine time of channel rd_ch |
| ser_data | output | 1 | Serial frame bit |
| ser_valid | output | 1 | High during each frame bit |
| busy | output | 1 | Readout in progress |
| done | output | 1 | One-cycle end-of-readout pulse |
| pend_mask | output | 16 | Channels still waiting to be sent |

## Verification
A channel pointer that skips or repeats a step shows up at the ports in two ways. The channel field of the next frame does not match the expected ascending channel list, and the done pulse moves away from 16 + 52·h cycles. A shift counter that is off by one changes the frame length, and that is visible as soon as ser_valid falls. A pending bit that is not cleared is caught when the first frame after it ends, because pend_mask is compared on every falling edge of ser_valid. A wrong Gray conversion corrupts the frame contents at once.

// File: rtl/hsr_pkg.sv
`timescale 1ns/1ps
package hsr_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCAN  = 2'd1,
    ST_SHIFT = 2'd2
  } rd_state_e;

  // Cycles from an accepted start to the done pulse
  function automatic int unsigned readout_cycles(input int unsigned nch,
                                                 input int unsigned hits,
                                                 input int unsigned fw);
    if (hits == 0) return 0;
    return nch + hits * fw;
  endfunction

endpackage

// File: rtl/chan_scan.sv
`timescale 1ns/1ps
module chan_scan #(
  parameter int NUM_CH = 16,
  parameter int CH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [NUM_CH-1:0] mask_in,
  input  logic              adv,
  input  logic              clr,
  output logic [CH_W-1:0]   ch,
  output logic [NUM_CH-1:0] pend,
  output logic              cur_hit,
  output logic              at_last
);
  localparam logic [CH_W-1:0] LAST_CH = CH_W'(NUM_CH - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
      ch   <= '0;
    end else if (load) begin
      pend <= mask_in;
      ch   <= '0;
    end else begin
      if (clr) pend[ch] <= 1'b0;
      if (adv) ch <= ch + 1'b1;
    end
  end

  assign cur_hit = pend[ch];
  assign at_last = (ch == LAST_CH);

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !pend[$past(ch)]);
  // R3
  pend_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((pend & ~$past(pend)) == '0));

endmodule

// File: rtl/frame_shift.sv
`timescale 1ns/1ps
module frame_shift #(
  parameter int FRAME_W = 52,
  parameter int CNT_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  output logic               sdo,
  output logic               active,
  output logic               last_bit
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg   <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      sreg   <= frame_in;
      cnt    <= '0;
      active <= 1'b1;
    end else if (active) begin
      sreg <= {sreg[FRAME_W-2:0], 1'b0};
      if (cnt == LAST_CNT) active <= 1'b0;
      else                 cnt    <= cnt + 1'b1;
    end
  end

  assign sdo      = sreg[FRAME_W-1];
  assign last_bit = active && (cnt == LAST_CNT);

  // R6
  load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !active);
  // R6
  frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_bit |=> !active);
  // R4
  first_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (sdo == $past(frame_in[FRAME_W-1])));

endmodule

// File: rtl/readout_fsm.sv
`timescale 1ns/1ps
module readout_fsm
  import hsr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mask_zero,
  input  logic cur_hit,
  input  logic at_last,
  input  logic last_bit,
  output logic load_mask,
  output logic adv,
  output logic clr,
  output logic load_frame,
  output logic busy,
  output logic done
);
  rd_state_e state, state_nxt;
  logic      done_nxt;

  always_comb begin
    state_nxt  = state;
    load_mask  = 1'b0;
    adv        = 1'b0;
    clr        = 1'b0;
    load_frame = 1'b0;
    done_nxt   = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        if (mask_zero) done_nxt = 1'b1;
        else begin
          load_mask = 1'b1;
          state_nxt = ST_SCAN;
        end
      end
      ST_SCAN: begin
        if (cur_hit) begin
          load_frame = 1'b1;
          state_nxt  = ST_SHIFT;
        end else if (at_last) begin
          done_nxt  = 1'b1;
          state_nxt = ST_IDLE;
        end else adv = 1'b1;
      end
      ST_SHIFT: if (last_bit) begin
        clr = 1'b1;
        if (at_last) begin
          done_nxt  = 1'b1;
          state_nxt = ST_IDLE;
        end else begin
          adv       = 1'b1;
          state_nxt = ST_SCAN;
        end
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nxt;
      done  <= done_nxt;
    end
  end

  assign busy = (state != ST_IDLE);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R8
  empty_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && mask_zero) |=> (done && !busy));
  // R10
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_mask |-> !busy);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

endmodule

// File: rtl/hit_serial_readout.sv
`timescale 1ns/1ps
module hit_serial_readout
  import hsr_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int TS_W   = 24,
  parameter int Q_W    = 12,
  parameter int T_W    = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [NUM_CH-1:0]          hit_mask,
  output logic                       rd_en,
  output logic [$clog2(NUM_CH)-1:0]  rd_ch,
  input  logic [TS_W-1:0]            rd_ts,
  input  logic [Q_W-1:0]             rd_charge,
  input  logic [T_W-1:0]             rd_time,
  output logic                       ser_data,
  output logic                       ser_valid,
  output logic                       busy,
  output logic                       done,
  output logic [NUM_CH-1:0]          pend_mask
);
  localparam int CH_W    = $clog2(NUM_CH);
  localparam int FRAME_W = CH_W + TS_W + Q_W + T_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam int SPAN_W  = $clog2(NUM_CH * (FRAME_W + 1) + 1) + 1;

  function automatic logic [CH_W-1:0] gray_ch(input logic [CH_W-1:0] b);
    return b ^ (b >> 1);
  endfunction
  function automatic logic [TS_W-1:0] gray_ts(input logic [TS_W-1:0] b);
    return b ^ (b >> 1);
  endfunction
  function automatic logic [Q_W-1:0] gray_q(input logic [Q_W-1:0] b);
    return b ^ (b >> 1);
  endfunction
  function automatic logic [T_W-1:0] gray_t(input logic [T_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  // Named internal events
  logic              ev_load_mask, ev_adv, ev_clr, ev_load_frame;
  logic              cur_hit, at_last, last_bit;
  logic [CH_W-1:0]   ch;
  logic [FRAME_W-1:0] frame_word;

  readout_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .mask_zero  (hit_mask == '0),
    .cur_hit    (cur_hit),
    .at_last    (at_last),
    .last_bit   (last_bit),
    .load_mask  (ev_load_mask),
    .adv        (ev_adv),
    .clr        (ev_clr),
    .load_frame (ev_load_frame),
    .busy       (busy),
    .done       (done)
  );

  chan_scan #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_scan (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ev_load_mask),
    .mask_in (hit_mask),
    .adv     (ev_adv),
    .clr     (ev_clr),
    .ch      (ch),
    .pend    (pend_mask),
    .cur_hit (cur_hit),
    .at_last (at_last)
  );

  assign rd_en = ev_load_frame;
  assign rd_ch = ch;
  assign frame_word = {gray_ch(ch), gray_ts(rd_ts), gray_q(rd_charge), gray_t(rd_time)};

  frame_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_load_frame),
    .frame_in (frame_word),
    .sdo      (ser_data),
    .active   (ser_valid),
    .last_bit (last_bit)
  );

  // Assertion support: span of a run and its hit count
  logic [SPAN_W-1:0] span_cnt;
  logic [CH_W:0]     hit_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      span_cnt <= '0;
      hit_cnt  <= '0;
    end else if (start && !busy) begin
      span_cnt <= '0;
      hit_cnt  <= (CH_W + 1)'($countones(hit_mask));
    end else if (busy) begin
      span_cnt <= span_cnt + 1'b1;
    end
  end

  // R3
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_valid |-> busy);
  // R7
  span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (32'(span_cnt) == readout_cycles(NUM_CH, 32'(hit_cnt), FRAME_W)));
  // R3
  read_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (pend_mask[rd_ch] && !ser_valid));

endmodule

// File: tb/hit_serial_readout_bench.sv
`timescale 1ns/1ps
module hit_serial_readout_bench;
  localparam int NCH = 16;
  localparam int FW  = 52;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] hit_mask = '0;
  logic        rd_en;
  logic [3:0]  rd_ch;
  logic [23:0] rd_ts;
  logic [11:0] rd_charge;
  logic [11:0] rd_time;
  logic        ser_data, ser_valid, busy, done;
  logic [15:0] pend_mask;

  int n_cmp = 0;
  int n_bad = 0;
  int seed  = 0;

  always #2 clk = ~clk;

  hit_serial_readout u_hit_serial_readout (
    .clk(clk), .rst_n(rst_n), .start(start), .hit_mask(hit_mask),
    .rd_en(rd_en), .rd_ch(rd_ch), .rd_ts(rd_ts), .rd_charge(rd_charge),
    .rd_time(rd_time), .ser_data(ser_data), .ser_valid(ser_valid),
    .busy(busy), .done(done), .pend_mask(pend_mask)
  );

  // Bank model
  function automatic logic [23:0] ts_of(input int c, input int s);
    return 24'(s * 9973 + c * 70001 + 5);
  endfunction
  function automatic logic [11:0] q_of(input int c, input int s);
    return 12'(s * 37 + c * 291 + 1);
  endfunction
  function automatic logic [11:0] t_of(input int c, input int s);
    return 12'((s * 113) ^ (c * 2741));
  endfunction
  assign rd_ts     = ts_of(int'(rd_ch), seed);
  assign rd_charge = q_of(int'(rd_ch), seed);
  assign rd_time   = t_of(int'(rd_ch), seed);

  // Bit-wise Gray restatement: each bit is XOR with its upper neighbour
  function automatic logic [23:0] to_gray(input logic [23:0] b, input int w);
    logic [23:0] r;
    r = '0;
    for (int i = 0; i < w; i++) r[i] = (i == w - 1) ? b[i] : (b[i] ^ b[i+1]);
    return r;
  endfunction

  function automatic logic [51:0] exp_frame(input int c, input int s);
    logic [23:0] gc, gt, gq, gf;
    gc = to_gray(24'(c), 4);
    gt = to_gray(ts_of(c, s), 24);
    gq = to_gray({12'h0, q_of(c, s)}, 12);
    gf = to_gray({12'h0, t_of(c, s)}, 12);
    return {gc[3:0], gt, gq[11:0], gf[11:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !ser_valid && pend_mask == '0, "R1 during reset",
        {busy, done, ser_valid, pend_mask}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !ser_valid && pend_mask == '0, "R1 after release",
        {busy, done, ser_valid, pend_mask}, 64'h0);
  endtask

  task automatic t_readout(input logic [15:0] mask, input int s, input bit inject);
    int list[16];
    int nh = 0;
    int fi = 0;
    int nb = 0;
    int k = 0;
    int nd = -1;
    int exp_n;
    bit busy_ok = 1'b1;
    logic [51:0] cap = '0;
    logic [15:0] exp_p;
    seed = s;
    for (int c = 0; c < NCH; c++) if (mask[c]) begin list[nh] = c; nh++; end
    exp_n = (nh == 0) ? 0 : NCH + FW * nh;
    @(negedge clk);
    hit_mask = mask;
    start = 1'b1;
    while (nd < 0 && k < 5000) begin
      @(negedge clk);
      if (k == 0) begin
        start = 1'b0;
        chk(pend_mask == mask, "R2 mask captured", 64'(pend_mask), 64'(mask));
        chk(busy == (nh != 0), "R2/R8 busy after start", 64'(busy), 64'(nh != 0));
      end
      if (ser_valid) begin
        cap = {cap[50:0], ser_data};
        nb++;
      end else if (nb > 0) begin
        chk(nb == FW, "R6 frame length", 64'(nb), 64'(FW));
        if (fi < nh) begin
          chk(cap == exp_frame(list[fi], s), "R3/R4/R5 frame content",
              64'(cap), 64'(exp_frame(list[fi], s)));
          exp_p = mask & ~16'((17'h1 << (list[fi] + 1)) - 17'h1);
          chk(pend_mask == exp_p, "R9 pending bit cleared", 64'(pend_mask), 64'(exp_p));
        end else begin
          chk(1'b0, "R3 extra frame", 64'(cap), 64'h0);
        end
        fi++;
        nb = 0;
      end
      if (done) begin
        nd = k;
        chk(!busy, "R11 busy low with done", 64'(busy), 64'h0);
      end else if (!busy) busy_ok = 1'b0;
      if (inject && k == 30) begin
        hit_mask = ~mask;
        start = 1'b1;
      end
      if (inject && k == 31) start = 1'b0;
      k++;
    end
    chk(nd == exp_n, "R7 done timing", 64'(nd), 64'(exp_n));
    chk(fi == nh, "R3 frame count", 64'(fi), 64'(nh));
    chk(pend_mask == '0, "R9 pending empty at end", 64'(pend_mask), 64'h0);
    chk(busy_ok, "R2 busy held until done", 64'(busy_ok), 64'h1);
    if (mask == 16'hFFFF) chk(nd <= 1000, "R7 full readout within 100us", 64'(nd), 64'd1000);
    if (inject) chk(fi == nh, "R10 start while busy ignored", 64'(fi), 64'(nh));
    @(negedge clk);
    chk(!done, "R11 done single cycle", 64'(done), 64'h0);
  endtask

  initial begin
    t_reset();
    t_readout(16'h0000, 1, 1'b0);
    t_readout(16'h0001, 2, 1'b0);
    t_readout(16'h8000, 3, 1'b0);
    t_readout(16'hA5C3, 4, 1'b0);
    t_readout(16'hFFFF, 5, 1'b0);
    t_readout(16'h0F0F, 6, 1'b1);
    t_readout(16'h0003, 7, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule